// File: doc/BRIEF.md
# Page-Write Load and Commit Controller

This block is the write engine of a byte-wide non-volatile store. It samples a chip-select strobe and a write strobe on every clock. A byte is loaded while both strobes are low. The byte offset is taken in the cycle the combined strobe is first seen active, and the data byte in the cycle it is first seen inactive. Up to one page of 64 bytes gathers in a page buffer. The page number comes from the first byte of the sequence.

Each further byte must begin within a bounded gap after the previous byte's start. Once no accepted byte has been active for an idle period, the controller closes the page on its own. It then runs a programming phase of fixed length and writes the loaded bytes into a register-array store. Bytes that were not loaded keep their old contents. A busy output covers the whole sequence. A program-allow input works as a write protect. Pulling it low blocks reads and loads, and it aborts a load or a programming phase without touching the store.

The strobes have no back-pressure. A host polls `busy`, and any strobe the controller cannot take is dropped. All time limits are parameters counted in clock cycles. The store keeps `STORE_PAGES` pages, and the page number is reduced modulo that count.

Top module: `page_write_ctrl`

## Requirements
- R1: After `rst_n` is released, `busy` is 0 and every location reads 0.
- R2: The strobe is active while `sel_n` and `wstb_n` are both 0. The byte offset `loc[5:0]` is taken in the cycle the strobe is first seen active, and `din` in the cycle it is first seen inactive. The page number `loc[14:6]` is taken only from the first byte of a sequence, and later bytes land in that page whatever their page bits.
- R3: One programming cycle writes 1 to 64 bytes. The stored page is the page number modulo `STORE_PAGES`.
- R4: After the first byte, a further strobe start is accepted only if it comes at most `GAP_CYC` cycles after the previous accepted start. Later starts are ignored.
- R5: Programming begins after `IDLE_CYC` cycles without an accepted byte active, and it lasts `PROG_CYC` cycles. `busy` rises in the cycle after the first strobe start. For a single one-cycle strobe, `busy` stays high for `IDLE_CYC+PROG_CYC+1` cycles.
- R6: Offsets not loaded in a sequence keep their stored values. If an offset is loaded twice, the last byte is stored.
- R7: Strobes that arrive during programming are ignored. They load nothing and start no new sequence.
- R8: While `pgm_allow` is 0, strobes are ignored and `dout` reads 0. Dropping `pgm_allow` during a load or programming phase abandons it: the store is unchanged and `busy` is 0 in the next cycle.
- R9: While `pgm_allow` is 1, `dout` shows the stored byte at `rloc` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the store |
| pgm_allow | input | 1 | High allows reads and programming; low aborts |
| sel_n | input | 1 | Chip-select strobe, active low |
| wstb_n | input | 1 | Write strobe, active low |
| loc | input | 15 | Write location: page in [14:6], offset in [5:0] |
| din | input | 8 | Write data byte |
| rloc | input | 15 | Read location |
| dout | output | 8 | Read data |
| busy | output | 1 | High from the first strobe until programming ends |

## Verification
The bench probes the load-gap boundary from both sides:
- At exactly `GAP_CYC` the byte must be stored. An off-by-one comparison would drop it.
- At `GAP_CYC+1` the byte must be ignored. An off-by-one in the other direction would let it in.

It changes the page bits in the middle of a sequence, which catches a design that re-captures the page on each byte. It strobes during programming, where a weak guard would load stray bytes or restart a sequence. It drops `pgm_allow` during programming, where a missing abort would commit the page or hold `busy`. It also measures the exact width of the `busy` pulse. Random pages with repeated offsets check that the last byte wins and that unloaded bytes survive.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_PROG = 2'd2
  } phase_t;
endpackage

// File: rtl/pwc_strobe_edge.sv
module pwc_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic wstb_n,
  output logic start_o,
  output logic end_o
);
  logic strb, strb_q;

  assign strb = ~sel_n & ~wstb_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= 1'b0;
    else        strb_q <= strb;
  end

  assign start_o = strb & ~strb_q;
  assign end_o   = ~strb & strb_q;
endmodule

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
  parameter int OFF_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr_i,
  input  logic                            wr_en_i,
  input  logic [OFF_W-1:0]                wr_off_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  output logic [(1<<OFF_W)-1:0][DATA_W-1:0] buf_o,
  output logic [(1<<OFF_W)-1:0]           mask_o
);
  localparam int BYTES = 1 << OFF_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_slot
    logic [DATA_W-1:0] val_q;
    logic              vld_q;
    logic              hit;
    assign hit = wr_en_i && (wr_off_i == OFF_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        vld_q <= 1'b0;
      end else if (clr_i) begin
        vld_q <= 1'b0;
      end else if (hit) begin
        val_q <= wr_data_i;
        vld_q <= 1'b1;
      end
    end
    assign buf_o[g]  = val_q;
    assign mask_o[g] = vld_q;
  end

  // A loaded byte is marked valid in the buffer (R6)
  p_mark_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !clr_i) |=> mask_o[$past(wr_off_i)]);
endmodule

// File: rtl/pwc_sequencer.sv
module pwc_sequencer
  import pwc_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int OFF_W    = 6,
  parameter int GAP_CYC  = 3750,
  parameter int IDLE_CYC = 12500,
  parameter int PROG_CYC = 1250000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    allow_i,
  input  logic                    start_i,
  input  logic                    end_i,
  input  logic [ADDR_W-1:0]       loc_i,
  output logic [ADDR_W-OFF_W-1:0] page_o,
  output logic                    wr_en_o,
  output logic [OFF_W-1:0]        wr_off_o,
  output logic                    commit_o,
  output logic                    clr_o,
  output logic                    busy_o
);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int GAP_W  = $clog2(GAP_CYC + 1);
  localparam int IDLE_W = $clog2(IDLE_CYC + 1);
  localparam int PROG_W = $clog2(PROG_CYC + 1);

  phase_t            ph_q;
  logic [GAP_W-1:0]  gap_q;
  logic [IDLE_W-1:0] idle_q;
  logic [PROG_W-1:0] prog_q;
  logic              in_byte_q;
  logic [OFF_W-1:0]  off_q;
  logic [PAGE_W-1:0] page_q;
  logic              win_open, take;

  assign win_open = gap_q < GAP_W'(GAP_CYC);
  assign take     = start_i && !in_byte_q && win_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      gap_q     <= '0;
      idle_q    <= '0;
      prog_q    <= '0;
      in_byte_q <= 1'b0;
      off_q     <= '0;
      page_q    <= '0;
    end else if (!allow_i) begin
      ph_q      <= PH_IDLE;
      in_byte_q <= 1'b0;
      gap_q     <= '0;
      idle_q    <= '0;
      prog_q    <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q      <= PH_LOAD;
          page_q    <= loc_i[ADDR_W-1:OFF_W];
          off_q     <= loc_i[OFF_W-1:0];
          in_byte_q <= 1'b1;
          gap_q     <= '0;
          idle_q    <= '0;
        end
        PH_LOAD: if (take) begin
          off_q     <= loc_i[OFF_W-1:0];
          in_byte_q <= 1'b1;
          gap_q     <= '0;
          idle_q    <= '0;
        end else begin
          if (win_open) gap_q <= gap_q + 1'b1;
          if (end_i && in_byte_q) begin
            in_byte_q <= 1'b0;
            idle_q    <= '0;
          end else if (!in_byte_q) begin
            if (idle_q == IDLE_W'(IDLE_CYC - 1)) begin
              ph_q   <= PH_PROG;
              prog_q <= '0;
            end else begin
              idle_q <= idle_q + 1'b1;
            end
          end
        end
        PH_PROG: begin
          if (prog_q == PROG_W'(PROG_CYC - 1)) ph_q <= PH_IDLE;
          else prog_q <= prog_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign page_o   = page_q;
  assign wr_off_o = off_q;
  assign wr_en_o  = allow_i && (ph_q == PH_LOAD) && end_i && in_byte_q;
  assign commit_o = allow_i && (ph_q == PH_PROG) && (prog_q == PROG_W'(PROG_CYC - 1));
  assign clr_o    = commit_o || !allow_i;
  assign busy_o   = (ph_q != PH_IDLE);

  p_busy_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && start_i && allow_i) |=> busy_o);
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !allow_i |=> !busy_o);
  p_prog_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PROG && start_i) |=> (ph_q != PH_LOAD));
  p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_LOAD) |=> $stable(page_o));
endmodule

// File: rtl/pwc_store.sv
module pwc_store #(
  parameter int ADDR_W      = 15,
  parameter int OFF_W       = 6,
  parameter int DATA_W      = 8,
  parameter int STORE_PAGES = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit_i,
  input  logic [ADDR_W-OFF_W-1:0]           page_i,
  input  logic [(1<<OFF_W)-1:0][DATA_W-1:0] buf_i,
  input  logic [(1<<OFF_W)-1:0]             mask_i,
  input  logic                              allow_i,
  input  logic [ADDR_W-1:0]                 rloc_i,
  output logic [DATA_W-1:0]                 dout_o
);
  localparam int BYTES  = 1 << OFF_W;
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(STORE_PAGES);

  logic [DATA_W-1:0] mem [STORE_PAGES][BYTES];
  logic [IDX_W-1:0]  widx, ridx;
  logic [PAGE_W-1:0] rpage;

  assign widx  = IDX_W'(page_i % PAGE_W'(STORE_PAGES));
  assign rpage = rloc_i[ADDR_W-1:OFF_W];
  assign ridx  = IDX_W'(rpage % PAGE_W'(STORE_PAGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < STORE_PAGES; p++)
        for (int b = 0; b < BYTES; b++)
          mem[p][b] <= '0;
    end else if (commit_i) begin
      for (int b = 0; b < BYTES; b++)
        if (mask_i[b]) mem[widx][b] <= buf_i[b];
    end
  end

  assign dout_o = allow_i ? mem[ridx][rloc_i[OFF_W-1:0]] : '0;

  // Without a commit, a steady read location keeps its data (R6)
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_i) ##1 (allow_i && $past(allow_i) && $stable(rloc_i)) |-> $stable(dout_o));
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int ADDR_W      = 15,
  parameter int OFF_W       = 6,
  parameter int DATA_W      = 8,
  parameter int STORE_PAGES = 8,
  parameter int GAP_CYC     = 3750,
  parameter int IDLE_CYC    = 12500,
  parameter int PROG_CYC    = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_allow,
  input  logic              sel_n,
  input  logic              wstb_n,
  input  logic [ADDR_W-1:0] loc,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] rloc,
  output logic [DATA_W-1:0] dout,
  output logic              busy
);
  localparam int BYTES  = 1 << OFF_W;
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic                         s_start, s_end;
  logic [PAGE_W-1:0]            page;
  logic                         wr_en, commit, clr;
  logic [OFF_W-1:0]             wr_off;
  logic [BYTES-1:0][DATA_W-1:0] pbuf;
  logic [BYTES-1:0]             pmask;

  pwc_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb_n(wstb_n),
    .start_o(s_start), .end_o(s_end)
  );

  pwc_sequencer #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .GAP_CYC(GAP_CYC),
    .IDLE_CYC(IDLE_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .allow_i(pgm_allow),
    .start_i(s_start), .end_i(s_end), .loc_i(loc),
    .page_o(page), .wr_en_o(wr_en), .wr_off_o(wr_off),
    .commit_o(commit), .clr_o(clr), .busy_o(busy)
  );

  pwc_page_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_en_i(wr_en),
    .wr_off_i(wr_off), .wr_data_i(din), .buf_o(pbuf), .mask_o(pmask)
  );

  pwc_store #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .STORE_PAGES(STORE_PAGES)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .page_i(page),
    .buf_i(pbuf), .mask_i(pmask), .allow_i(pgm_allow),
    .rloc_i(rloc), .dout_o(dout)
  );

  // No commit reaches the store while programming is blocked (R8)
  p_no_commit_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_allow |-> !commit);
endmodule

// File: tb/tb_page_write_ctrl.sv
module tb_page_write_ctrl;
  localparam int GAP   = 8;
  localparam int IDLE  = 20;
  localparam int PROG  = 30;
  localparam int PAGES = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pgm_allow = 1'b1;
  logic        sel_n = 1'b1;
  logic        wstb_n = 1'b1;
  logic [14:0] loc = '0;
  logic [7:0]  din = '0;
  logic [14:0] rloc = '0;
  logic [7:0]  dout;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] ref_mem [0:PAGES*64-1];
  logic [7:0] pend_val [0:63];
  bit         pend_v [0:63];

  always #4 clk = ~clk;

  page_write_ctrl #(
    .STORE_PAGES(PAGES), .GAP_CYC(GAP), .IDLE_CYC(IDLE), .PROG_CYC(PROG)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pgm_allow(pgm_allow), .sel_n(sel_n),
    .wstb_n(wstb_n), .loc(loc), .din(din), .rloc(rloc), .dout(dout), .busy(busy)
  );

  function automatic int ref_idx(input int page, input int off);
    return (page % PAGES) * 64 + off;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe_byte(input int page, input int off, input int val);
    @(negedge clk);
    sel_n = 1'b0; wstb_n = 1'b0;
    loc = 15'((page << 6) | off);
    din = 8'(val);
    @(negedge clk);
    sel_n = 1'b1; wstb_n = 1'b1;
  endtask

  task automatic clear_pend();
    for (int i = 0; i < 64; i++) pend_v[i] = 1'b0;
  endtask

  task automatic note(input int off, input int val);
    pend_v[off] = 1'b1;
    pend_val[off] = 8'(val);
  endtask

  task automatic apply(input int page);
    for (int i = 0; i < 64; i++)
      if (pend_v[i]) ref_mem[ref_idx(page, i)] = pend_val[i];
  endtask

  task automatic wait_idle();
    int lim = 0;
    while (busy && lim < 2000) begin
      @(negedge clk);
      lim++;
    end
  endtask

  task automatic read_chk(input int page, input int off, input string req);
    @(negedge clk);
    rloc = 15'((page << 6) | off);
    #1;
    chk(dout == ref_mem[ref_idx(page, off)], req, dout, ref_mem[ref_idx(page, off)]);
  endtask

  task automatic page_chk(input int page, input string req);
    for (int i = 0; i < 64; i++) read_chk(page, i, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    int cnt;
    seed = $urandom(32'd4242);
    for (int i = 0; i < PAGES * 64; i++) ref_mem[i] = 8'h00;
    clear_pend();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    read_chk(0, 0, "R1 read");
    read_chk(5, 33, "R1 read");
    read_chk(7, 63, "R1 read");

    // R5: busy timing for a single byte; R9 read-back
    clear_pend();
    strobe_byte(3, 5, 8'hA5);
    note(5, 8'hA5);
    chk(busy == 1'b1, "R5 busy rise", busy, 1);
    cnt = 0;
    while (busy && cnt < 2000) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == IDLE + PROG + 1, "R5 busy length", cnt, IDLE + PROG + 1);
    apply(3);
    read_chk(3, 5, "R9 read");
    read_chk(3, 4, "R6 untouched");

    // R2: page bits of later bytes are ignored
    clear_pend();
    strobe_byte(2, 1, 8'h11); note(1, 8'h11);
    strobe_byte(5, 2, 8'h22); note(2, 8'h22);
    wait_idle();
    apply(2);
    read_chk(2, 1, "R2 first byte");
    read_chk(2, 2, "R2 page from first");
    read_chk(5, 2, "R2 other page untouched");

    // R4: start exactly GAP cycles later is accepted
    clear_pend();
    strobe_byte(1, 10, 8'h5A); note(10, 8'h5A);
    repeat (GAP - 2) @(negedge clk);
    strobe_byte(1, 11, 8'hB6); note(11, 8'hB6);
    wait_idle();
    apply(1);
    read_chk(1, 11, "R4 gap boundary accepted");

    // R4: start GAP+1 cycles later is ignored
    clear_pend();
    strobe_byte(1, 20, 8'h6C); note(20, 8'h6C);
    repeat (GAP - 1) @(negedge clk);
    strobe_byte(1, 21, 8'hE1);
    wait_idle();
    apply(1);
    read_chk(1, 20, "R4 first stored");
    read_chk(1, 21, "R4 late byte ignored");

    // R7: strobes during programming are ignored
    clear_pend();
    strobe_byte(4, 0, 8'h3C); note(0, 8'h3C);
    repeat (IDLE + 5) @(negedge clk);
    chk(busy == 1'b1, "R7 in programming", busy, 1);
    strobe_byte(4, 1, 8'hC3);
    strobe_byte(7, 0, 8'h99);
    wait_idle();
    apply(4);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R7 no new sequence", busy, 0);
    read_chk(4, 0, "R7 committed");
    read_chk(4, 1, "R7 ignored byte");
    read_chk(7, 0, "R7 ignored page");

    // R8: abort during programming, blocked reads and strobes
    clear_pend();
    strobe_byte(4, 0, 8'h77);
    repeat (IDLE + 5) @(negedge clk);
    pgm_allow = 1'b0;
    rloc = 15'((4 << 6) | 0);
    @(negedge clk);
    chk(busy == 1'b0, "R8 abort busy", busy, 0);
    chk(dout == 8'h00, "R8 read blocked", dout, 0);
    strobe_byte(6, 3, 8'h44);
    @(negedge clk);
    chk(busy == 1'b0, "R8 strobe blocked", busy, 0);
    pgm_allow = 1'b1;
    repeat (IDLE + PROG + 5) @(negedge clk);
    read_chk(4, 0, "R8 store unchanged");
    read_chk(6, 3, "R8 blocked strobe not stored");

    // R3: full 64-byte page and page aliasing modulo STORE_PAGES
    clear_pend();
    for (int i = 0; i < 64; i++) begin
      strobe_byte(9, i, (i * 7 + 3) & 8'hFF);
      note(i, (i * 7 + 3) & 8'hFF);
    end
    wait_idle();
    apply(9);
    page_chk(1, "R3 full page alias");

    // R6: random pages with repeats and unloaded bytes
    for (int r = 0; r < 16; r++) begin
      int pg, n;
      pg = $urandom_range(0, 511);
      n = $urandom_range(1, 24);
      clear_pend();
      for (int i = 0; i < n; i++) begin
        int off, val, k;
        off = $urandom_range(0, 63);
        val = $urandom_range(0, 255);
        k = $urandom_range(0, GAP - 3);
        if (i > 0) repeat (k) @(negedge clk);
        strobe_byte(pg, off, val);
        note(off, val);
      end
      wait_idle();
      apply(pg);
      page_chk(pg, "R6 random page");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule